// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block produces a periodic interrupt at an interval set by software. It holds a 16-bit down-counter, a 16-bit reload register and an 8-bit scale register. A prescaler divides the clock by the scale value plus one. Each time the prescaler expires, the down-counter steps once. A step taken while the counter already reads zero does not decrement. It reloads the counter from the reload register and raises a one-cycle interrupt pulse.

Software loads the three registers through separate write strobes that share one data bus. The live count can be read at any time. A single enable input pauses or runs the whole timer. While the timer is enabled, one interrupt occurs every (P+1)·(S+1) cycles, where P is the reload value and S is the scale value.

Top module: `interval_timer`

## Requirements
- R1: During reset and on the first cycle after it, `count_o` reads 0 and `irq_o` is low. The internal reload value, scale value and prescaler also start at 0.
- R2: When `wr_count` is high at a clock edge, `count_o` shows `wr_data` after that edge, whatever the state of `enable`. The same write restarts the prescaler from the current scale value, so the next step comes scale+1 enabled cycles later.
- R3: With scale value S, an enabled counter changes once every S+1 enabled cycles. Each change is a decrement by exactly 1 while the count is nonzero.
- R4: A step taken while the count is 0 loads the count from the reload value. In the cycle that the reloaded count is first visible on `count_o`, `irq_o` is high for that one cycle.
- R5: With the timer enabled and no writes, consecutive `irq_o` pulses are (P+1)·(S+1) cycles apart.
- R6: While `enable` is low, `count_o` and the prescaler hold their values and `irq_o` stays low.
- R7: A `wr_count` write in the same cycle as a step or a reload wins. No decrement and no interrupt come from that cycle.
- R8: A write to the reload register (`wr_period`, 16 bits) or the scale register (`wr_scale`, low 8 bits of `wr_data`) leaves `count_o` unchanged. The new reload value is used at the next reload, and the new scale value at the next prescaler restart.
- R9: A scale value of 0 makes the counter step on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run (1) or pause (0) the timer |
| wr_count | input | 1 | Load the down-counter from `wr_data` |
| wr_period | input | 1 | Load the reload register from `wr_data` |
| wr_scale | input | 1 | Load the scale register from `wr_data[7:0]` |
| wr_data | input | 16 | Write data shared by the three strobes |
| count_o | output | 16 | Live value of the down-counter |
| irq_o | output | 1 | Interrupt pulse, one cycle per reload |

## Verification
Every result of this block is registered. A write, a step, a reload or an interrupt shows on the ports one clock edge after the edge that samples the strobe or the prescaler expiry. The bench drives inputs on falling edges. A behavioural model advances on the same rising edge as the design, and both outputs are compared on the next falling edge, so the check lands on the first cycle where the new value is due. The interrupt spacing of R5 and the silence of R6 are also measured directly by counting cycles between pulses.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_count,
  input  logic             wr_period,
  input  logic             wr_scale,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [SCL_W-1:0] SCL_ONE = SCL_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q;
  logic [SCL_W-1:0] scl_q, pre_q;
  logic             irq_q;

  wire pre_done = (pre_q == '0);
  wire tick     = enable && !wr_count && pre_done;
  wire at_zero  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      scl_q <= '0;
      pre_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_count) begin
        cnt_q <= wr_data;
        pre_q <= scl_q;
      end else if (enable) begin
        pre_q <= pre_done ? scl_q : pre_q - SCL_ONE;
        if (pre_done) cnt_q <= at_zero ? per_q : cnt_q - CNT_ONE;
      end
      if (wr_period) per_q <= wr_data;
      if (wr_scale)  scl_q <= wr_data[SCL_W-1:0];
      irq_q <= tick && at_zero;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> count_o == $past(wr_data)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> !irq_o); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wr_count && cnt_q != '0) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - CNT_ONE)); // R3
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wr_count && pre_q != '0) |=> $stable(count_o)); // R3
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> count_o == $past(per_q)); // R4
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_count) |=> ($stable(count_o) && $stable(pre_q))); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq_o); // R6
  AST_CFG_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_count && (wr_period || wr_scale)) |=> $stable(count_o)); // R8

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_count = 1'b0, wr_period = 1'b0, wr_scale = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        irq_o;

  always #2 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_count(wr_count),
    .wr_period(wr_period), .wr_scale(wr_scale), .wr_data(wr_data),
    .count_o(count_o), .irq_o(irq_o));

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  int m_cnt = 0, m_per = 0, m_scl = 0, m_pre = 0;
  bit m_irq = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_scl = 0; m_pre = 0; m_irq = 0;
    end else begin
      bit nirq;
      nirq = 0;
      if (wr_count) begin
        m_cnt = wr_data; m_pre = m_scl;
      end else if (enable) begin
        if (m_pre == 0) begin
          m_pre = m_scl;
          if (m_cnt == 0) begin m_cnt = m_per; nirq = 1; end
          else m_cnt = m_cnt - 1;
        end else m_pre = m_pre - 1;
      end
      if (wr_period) m_per = wr_data;
      if (wr_scale)  m_scl = wr_data & 255;
      m_irq = nirq;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, count_o, m_cnt, "count_o");
    check(cur_req, irq_o, m_irq, "irq_o");
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int sel, int val);
    wr_data = val[15:0];
    wr_count = (sel == 0); wr_period = (sel == 1); wr_scale = (sel == 2);
    @(negedge clk);
    wr_count = 0; wr_period = 0; wr_scale = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    finish_run();
  end

  initial begin
    int t0, gap, irqs;
    logic [15:0] lfsr;
    idle(3);
    check("R1", count_o, 0, "count_o in reset");
    check("R1", irq_o, 0, "irq_o in reset");
    rst_n = 1'b1;
    idle(1);
    check("R1", count_o, 0, "count_o after reset");

    cur_req = "R9";
    wr(1, 3); wr(0, 2); enable = 1; idle(20);

    cur_req = "R3";
    enable = 0; wr(2, 4); wr(1, 2); wr(0, 5); enable = 1; idle(60);

    cur_req = "R5";
    enable = 0; wr(2, 2); wr(1, 4); wr(0, 0); enable = 1;
    while (!irq_o) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!irq_o) @(negedge clk);
    gap = cyc - t0;
    check("R5", gap, 15, "irq spacing P=4 S=2");

    cur_req = "R6";
    enable = 0; irqs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq_o) irqs++; end
    check("R6", irqs, 0, "irq pulses while disabled");
    wr(1, 9); wr(2, 1);
    cur_req = "R8"; idle(5);
    cur_req = "R2"; wr(0, 7); idle(3); enable = 1; idle(10);

    cur_req = "R7";
    wr(2, 0); wr(0, 0); wr(0, 0); wr(0, 1); wr(0, 0); idle(4);

    cur_req = "R8";
    wr(2, 3); idle(7); wr(1, 1); idle(40);

    cur_req = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      enable = (lfsr[2:0] != 0);
      wr_data = {12'h0, lfsr[7:4]};
      wr_count  = (lfsr[15:11] == 0);
      wr_period = (lfsr[15:11] == 1);
      wr_scale  = (lfsr[15:11] == 2);
      @(negedge clk);
    end
    wr_count = 0; wr_period = 0; wr_scale = 0;
    idle(5);
    finish_run();
  end
endmodule